// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a DMA controller. Software loads a descriptor made of a control word and two pointers that name the inclusive last source address and the inclusive last destination address. When a request arrives, the engine copies items one at a time over a simple memory port. Each item is one read followed by one write of the data that was read. Each side of the copy can step backwards from its end pointer by a byte, a half-word or a word per item, or it can stay on one fixed address, as a peripheral data register does.

The remaining item count in the control word holds N-1. The address of the current item on each side is the end pointer minus the remaining count scaled by that side's step. The engine therefore needs no separate address registers, and the last item always lands exactly on the end pointer. In basic mode a peripheral request releases a group of items: a single request releases one item, and a burst or software request releases a power-of-two group. In auto mode one request drains the whole descriptor. When the last item has been written, the engine sets its own mode field to stop and pulses a completion output.

Top module: `dmae_engine`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `mem_valid` and `done` are 0 and `ctrl_word` is all zeros, which is the stop mode.
- R2: Control word fields: mode in bits [1:0] (0 stop, 1 basic, 2 auto), burst-only flag in bit 2, remaining count N-1 in bits [12:3], log2 of the group size in bits [16:13] (0..10), item size in bits [18:17] (0 byte, 1 half, 2 word), source step in bits [20:19] and destination step in bits [22:21] (0 byte, 1 half, 2 word, 3 fixed). Item k of N (counting from 0) uses address end - (N-1-k) x step, where the step is 1, 2 or 4. With step code 3 the address is the end pointer itself, whatever the item size.
- R3: Each item is one read at the source address followed by one write at the destination address. A request is held until `mem_ready` is seen, and only one access is outstanding at a time. `mem_size` equals the item size code, and `mem_wdata` equals the `mem_rdata` returned by the preceding read.
- R4: In basic mode, a burst or software request that stays asserted moves min(2^G, remaining) items, where G is the group size field. The engine then goes idle and the count field has dropped by that number.
- R5: In basic mode, if the triggering request is low when an item's write completes, no further item of that group starts.
- R6: A single request moves exactly one item in basic mode, even if it stays high. When the burst-only flag is 1, single requests start nothing and leave `ctrl_word` unchanged.
- R7: In auto mode, one request of any accepted kind, even a one-cycle pulse, moves every remaining item. The group size field and the request level are ignored.
- R8: When the item with count field 0 completes, the mode field becomes 0 and `done` is high for exactly one cycle.
- R9: With mode field 0, requests cause no memory access and do not change `ctrl_word`.
- R10: `cfg_load` is ignored while `busy` is high. A transfer in progress keeps its pointers and its control fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load descriptor when idle |
| cfg_src_end | input | AW | Inclusive last source address |
| cfg_dst_end | input | AW | Inclusive last destination address |
| cfg_ctrl | input | 32 | Control word to load |
| req_single | input | 1 | Peripheral single-item request |
| req_burst | input | 1 | Peripheral group request |
| req_sw | input | 1 | Software request |
| ctrl_word | output | 32 | Current control word, including count and mode write-back |
| busy | output | 1 | A group is being moved |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_size | output | 2 | Item size code |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_rdata | input | DW | Read data, valid with `mem_ready` on a read |

## Verification
The bench targets the addresses at both ends of a descriptor. It uses a 1024-item run whose first destination address lies exactly 1023 words below the end pointer, and mixes steps that differ from the item size. An engine that counted up, or scaled the step by the item size, would put accesses on the wrong address. Some cases release a group that is larger than the items left, drop a held burst request in the middle of a group, hold a single request high, or send a request to a burst-only or stopped descriptor. A design that overran the group, ignored the drop, repeated single items or woke up in stop mode would make accesses the scoreboard does not expect. A reload attempted in the middle of a long auto run must leave the control word and the addresses untouched.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

    localparam int CNT_W        = 10;
    localparam int ARB_W        = 4;
    localparam int MAX_ARB_LOG2 = 10;
    localparam int CTRL_W       = 32;

    typedef enum logic [1:0] {
        MODE_STOP  = 2'd0,
        MODE_BASIC = 2'd1,
        MODE_AUTO  = 2'd2,
        MODE_RSVD  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        INC_BYTE = 2'd0,
        INC_HALF = 2'd1,
        INC_WORD = 2'd2,
        INC_NONE = 2'd3
    } inc_e;

    typedef enum logic [1:0] {
        KIND_SINGLE = 2'd0,
        KIND_BURST  = 2'd1,
        KIND_SOFT   = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    // packed MSB first: 32 bits total
    typedef struct packed {
        logic [8:0]       rsvd;
        inc_e             dst_inc;
        inc_e             src_inc;
        size_e            isize;
        logic [ARB_W-1:0] arb_log2;
        logic [CNT_W-1:0] cnt_m1;
        logic             burst_only;
        mode_e            mode;
    } ctrl_t;

    // items in one group: 2^arb (clamped) limited by what remains
    function automatic logic [CNT_W:0] group_len(
        input logic [ARB_W-1:0] arb,
        input logic [CNT_W-1:0] cnt_m1
    );
        logic [ARB_W-1:0] eff;
        logic [CNT_W:0]   lim;
        logic [CNT_W:0]   rem;
        eff = (arb > ARB_W'(MAX_ARB_LOG2)) ? ARB_W'(MAX_ARB_LOG2) : arb;
        lim = (CNT_W+1)'(1) << eff;
        rem = {1'b0, cnt_m1} + (CNT_W+1)'(1);
        return (lim < rem) ? lim : rem;
    endfunction

endpackage

// File: rtl/dmae_addr_gen.sv
module dmae_addr_gen
    import dmae_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    end_ptr,
    input  logic [CNT_W-1:0] remain,
    input  inc_e             inc,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] span;

    always_comb begin
        span = AW'(remain);
        unique case (inc)
            INC_BYTE: addr = end_ptr - span;
            INC_HALF: addr = end_ptr - (span << 1);
            INC_WORD: addr = end_ptr - (span << 2);
            default:  addr = end_ptr;
        endcase
    end
endmodule

// File: rtl/dmae_trigger.sv
module dmae_trigger
    import dmae_pkg::*;
(
    input  mode_e            mode,
    input  logic             burst_only,
    input  logic [ARB_W-1:0] arb_log2,
    input  logic [CNT_W-1:0] cnt_m1,
    input  logic             req_single,
    input  logic             req_burst,
    input  logic             req_sw,
    output logic             start,
    output req_kind_e        kind,
    output logic [CNT_W:0]   len,
    output logic             unlimited
);
    logic armed;

    always_comb begin
        armed     = (mode == MODE_BASIC) || (mode == MODE_AUTO);
        unlimited = (mode == MODE_AUTO);
        start     = 1'b0;
        kind      = KIND_SOFT;
        len       = group_len(arb_log2, cnt_m1);
        if (armed) begin
            if (req_sw) begin
                start = 1'b1;
                kind  = KIND_SOFT;
            end else if (req_burst) begin
                start = 1'b1;
                kind  = KIND_BURST;
            end else if (req_single && !burst_only) begin
                start = 1'b1;
                kind  = KIND_SINGLE;
                len   = (CNT_W+1)'(1);
            end
        end
    end
endmodule

// File: rtl/dmae_sequencer.sv
module dmae_sequencer
    import dmae_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           hold_off,
    input  req_kind_e      kind_in,
    input  logic [CNT_W:0] len_in,
    input  logic           unl_in,
    input  logic           last_item,
    input  logic [AW-1:0]  src_addr,
    input  logic [AW-1:0]  dst_addr,
    input  logic           req_single,
    input  logic           req_burst,
    input  logic           req_sw,
    input  logic           mem_ready,
    input  logic [DW-1:0]  mem_rdata,
    output logic           busy,
    output logic           item_done,
    output logic           mem_valid,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata
);
    seq_state_e     state_q;
    req_kind_e      kind_q;
    logic [CNT_W:0] left_q;
    logic           unl_q;
    logic [DW-1:0]  data_q;
    logic           held;
    logic           group_end;

    always_comb begin
        unique case (kind_q)
            KIND_SINGLE: held = req_single;
            KIND_BURST:  held = req_burst;
            default:     held = req_sw;
        endcase
        group_end = last_item ||
                    (!unl_q && ((left_q == (CNT_W+1)'(1)) || !held));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_SOFT;
            left_q  <= '0;
            unl_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start && !hold_off) begin
                        state_q <= ST_READ;
                        kind_q  <= kind_in;
                        left_q  <= len_in;
                        unl_q   <= unl_in;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        data_q  <= mem_rdata;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        left_q  <= left_q - (CNT_W+1)'(1);
                        state_q <= group_end ? ST_IDLE : ST_READ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_valid = busy;
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = mem_we ? dst_addr : src_addr;
        mem_wdata = data_q;
        item_done = mem_we && mem_ready;
    end
endmodule

// File: rtl/dmae_engine.sv
module dmae_engine
    import dmae_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_src_end,
    input  logic [AW-1:0] cfg_dst_end,
    input  logic [31:0]   cfg_ctrl,
    input  logic          req_single,
    input  logic          req_burst,
    input  logic          req_sw,
    output logic [31:0]   ctrl_word,
    output logic          busy,
    output logic          done,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [1:0]    mem_size,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata
);
    localparam int SIDES = 2;

    ctrl_t          ctrl_q;
    logic [AW-1:0]  src_end_q;
    logic [AW-1:0]  dst_end_q;
    logic           item_done;
    logic           trig_start;
    req_kind_e      trig_kind;
    logic [CNT_W:0] trig_len;
    logic           trig_unl;

    logic [AW-1:0]  side_end  [SIDES];
    inc_e           side_inc  [SIDES];
    logic [AW-1:0]  side_addr [SIDES];

    always_comb begin
        side_end[0] = src_end_q;
        side_inc[0] = ctrl_q.src_inc;
        side_end[1] = dst_end_q;
        side_inc[1] = ctrl_q.dst_inc;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dmae_addr_gen #(.AW(AW)) u_addr (
            .end_ptr (side_end[s]),
            .remain  (ctrl_q.cnt_m1),
            .inc     (side_inc[s]),
            .addr    (side_addr[s])
        );
    end

    dmae_trigger u_trig (
        .mode       (ctrl_q.mode),
        .burst_only (ctrl_q.burst_only),
        .arb_log2   (ctrl_q.arb_log2),
        .cnt_m1     (ctrl_q.cnt_m1),
        .req_single (req_single),
        .req_burst  (req_burst),
        .req_sw     (req_sw),
        .start      (trig_start),
        .kind       (trig_kind),
        .len        (trig_len),
        .unlimited  (trig_unl)
    );

    dmae_sequencer #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (trig_start),
        .hold_off   (cfg_load),
        .kind_in    (trig_kind),
        .len_in     (trig_len),
        .unl_in     (trig_unl),
        .last_item  (ctrl_q.cnt_m1 == '0),
        .src_addr   (side_addr[0]),
        .dst_addr   (side_addr[1]),
        .req_single (req_single),
        .req_burst  (req_burst),
        .req_sw     (req_sw),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .item_done  (item_done),
        .mem_valid  (mem_valid),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    // descriptor state: load when idle, count down and self-stop while running
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            src_end_q <= '0;
            dst_end_q <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (item_done) begin
                if (ctrl_q.cnt_m1 == '0) begin
                    ctrl_q.mode <= MODE_STOP;
                    done        <= 1'b1;
                end else begin
                    ctrl_q.cnt_m1 <= ctrl_q.cnt_m1 - CNT_W'(1);
                end
            end else if (cfg_load && !busy) begin
                ctrl_q    <= ctrl_t'(cfg_ctrl);
                src_end_q <= cfg_src_end;
                dst_end_q <= cfg_dst_end;
            end
        end
    end

    assign ctrl_word = ctrl_q;
    assign mem_size  = ctrl_q.isize;
endmodule

// File: rtl/dmae_engine_chk.sv
module dmae_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_load,
    input logic          busy,
    input logic          done,
    input logic          mem_valid,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   ctrl_word,
    input logic [AW-1:0] src_end_q,
    input logic [AW-1:0] dst_end_q
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_valid && !busy && !done));

    a_r2_fixed_dst: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_we && ctrl_word[22:21] == 2'd3) |-> (mem_addr == dst_end_q));

    a_r3_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    a_r3_read_then_write: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !mem_we) |=> (mem_valid && mem_we));

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_stopped: assert property (@(posedge clk) disable iff (rst)
        done |-> (ctrl_word[1:0] == 2'd0 && ctrl_word[12:3] == 10'd0));

    a_r9_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_word[1:0] == 2'd0) |=> !mem_valid);

    a_r10_load_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_load) |=> ($stable(src_end_q) && $stable(dst_end_q)));
endmodule

bind dmae_engine dmae_engine_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .busy      (busy),
    .done      (done),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .ctrl_word (ctrl_word),
    .src_end_q (src_end_q),
    .dst_end_q (dst_end_q)
);

// File: tb/dmae_engine_test.sv
module dmae_engine_test;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_src_end = '0;
    logic [AW-1:0] cfg_dst_end = '0;
    logic [31:0]   cfg_ctrl = '0;
    logic          req_single = 1'b0;
    logic          req_burst = 1'b0;
    logic          req_sw = 1'b0;
    logic [31:0]   ctrl_word;
    logic          busy;
    logic          done;
    logic          mem_valid;
    logic          mem_we;
    logic [1:0]    mem_size;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
        string       req;
    } op_t;

    op_t exp_q[$];
    int  compared = 0;
    int  mismatched = 0;
    int  wr_seen = 0;
    int  done_seen = 0;
    bit  busy_seen = 0;

    always #4 clk = ~clk;

    dmae_engine #(.AW(AW), .DW(DW)) uut (.*);

    function automatic logic [31:0] mem_fn(logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    function automatic logic [31:0] mk_ctrl(int mode, bit bo, int n, int arb,
                                            int sz, int sinc, int dinc);
        logic [31:0] c;
        c = '0;
        c[1:0]   = 2'(mode);
        c[2]     = bo;
        c[12:3]  = 10'(n - 1);
        c[16:13] = 4'(arb);
        c[18:17] = 2'(sz);
        c[20:19] = 2'(sinc);
        c[22:21] = 2'(dinc);
        return c;
    endfunction

    function automatic logic [31:0] addr_of(logic [31:0] e, logic [1:0] inc, int r);
        if (inc == 2'd3) return e;
        return e - (32'(r) << inc);
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // push expected read/write pairs for items first..first+n-1
    task automatic expect_items(logic [31:0] s, logic [31:0] d, logic [31:0] c,
                                int first, int n, string req);
        int total;
        total = int'(c[12:3]) + 1;
        for (int k = first; k < first + n; k++) begin
            op_t rd;
            op_t wr;
            int  r;
            r = total - 1 - k;
            rd.we = 0; rd.addr = addr_of(s, c[20:19], r); rd.size = c[18:17];
            rd.data = '0; rd.req = req;
            wr.we = 1; wr.addr = addr_of(d, c[22:21], r); wr.size = c[18:17];
            wr.data = mem_fn(rd.addr); wr.req = req;
            exp_q.push_back(rd);
            exp_q.push_back(wr);
        end
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        bit  rn;
        op_t e;
        if (rst) begin
            mem_ready = 1'b0;
        end else begin
            rn = mem_valid && !mem_ready;
            if (rn) begin
                if (exp_q.size() == 0) begin
                    check(0, "R3", "unexpected access at", mem_addr, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(mem_we == e.we && mem_addr == e.addr && mem_size == e.size,
                          e.req, "access addr", mem_addr, e.addr);
                    if (e.we)
                        check(mem_wdata == e.data, "R3", "write data", mem_wdata, e.data);
                end
                if (!mem_we) mem_rdata = mem_fn(mem_addr);
                else wr_seen++;
            end
            mem_ready = rn;
            if (done) done_seen++;
            if (busy) busy_seen = 1;
        end
    end

    task automatic load(logic [31:0] s, logic [31:0] d, logic [31:0] c);
        @(negedge clk);
        cfg_src_end = s; cfg_dst_end = d; cfg_ctrl = c; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic set_req(int which, bit v);
        case (which)
            0: req_single = v;
            1: req_burst = v;
            default: req_sw = v;
        endcase
    endtask

    task automatic pulse_req(int which);
        set_req(which, 1'b1);
        @(negedge clk);
        set_req(which, 1'b0);
    endtask

    task automatic hold_group(int which);
        set_req(which, 1'b1);
        @(negedge clk);
        while (busy) @(negedge clk);
        set_req(which, 1'b0);
    endtask

    task automatic wait_idle();
        while (busy || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual %0d expected %0d pending ops", exp_q.size(), 0);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic [31:0] d;
        logic [31:0] c;
        int          d0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !mem_valid && !done, "R1", "idle flags", {busy, mem_valid, done}, 0);
        check(ctrl_word == 32'h0, "R1", "ctrl_word", ctrl_word, 32'h0);

        // R7/R2: auto, word items, src word step, dst fixed
        s = 32'h1000_0010; d = 32'h4000_0000; c = mk_ctrl(2, 0, 5, 0, 2, 2, 3);
        load(s, d, c);
        expect_items(s, d, c, 0, 5, "R7");
        pulse_req(2);
        wait_idle();
        check(done_seen == 1, "R8", "done pulses", done_seen, 1);
        check(ctrl_word[1:0] == 2'd0, "R8", "mode after end", ctrl_word[1:0], 0);
        check(ctrl_word[12:3] == 10'd0, "R8", "count after end", ctrl_word[12:3], 0);

        // R4: basic, group of 4 out of 6, byte items, src byte, dst half
        s = 32'h2000_0105; d = 32'h3000_0200; c = mk_ctrl(1, 0, 6, 2, 0, 0, 1);
        load(s, d, c);
        expect_items(s, d, c, 0, 4, "R4");
        hold_group(1);
        wait_idle();
        check(ctrl_word[12:3] == 10'd1, "R4", "count after group", ctrl_word[12:3], 1);
        check(ctrl_word[1:0] == 2'd1, "R4", "mode mid descriptor", ctrl_word[1:0], 1);
        check(done_seen == 1, "R4", "no done mid descriptor", done_seen, 1);
        // R8: second group shorter than group size, then completion
        expect_items(s, d, c, 4, 2, "R8");
        hold_group(1);
        wait_idle();
        check(done_seen == 2, "R8", "done after last", done_seen, 2);
        check(ctrl_word[1:0] == 2'd0, "R8", "mode written to stop", ctrl_word[1:0], 0);

        // R6: single request held high moves one item
        s = 32'h0000_8000; d = 32'h0000_9000; c = mk_ctrl(1, 0, 3, 3, 1, 1, 2);
        load(s, d, c);
        expect_items(s, d, c, 0, 1, "R6");
        hold_group(0);
        wait_idle();
        check(ctrl_word[12:3] == 10'd1, "R6", "count after single", ctrl_word[12:3], 1);

        // R6: burst-only descriptor ignores single requests
        c = mk_ctrl(1, 1, 4, 2, 2, 2, 2);
        load(32'h0000_1000, 32'h0000_2000, c);
        busy_seen = 0;
        req_single = 1'b1;
        repeat (6) @(negedge clk);
        req_single = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy_seen, "R6", "busy on ignored single", 32'(busy_seen), 0);
        check(ctrl_word == c, "R6", "ctrl after ignored single", ctrl_word, c);

        // R5: dropping burst request mid group stops after current item
        s = 32'h5000_0100; d = 32'h6000_0040; c = mk_ctrl(1, 0, 20, 3, 2, 2, 0);
        load(s, d, c);
        expect_items(s, d, c, 0, 3, "R5");
        wr_seen = 0;
        req_burst = 1'b1;
        while (wr_seen < 2) @(posedge clk);
        @(negedge clk);
        req_burst = 1'b0;
        wait_idle();
        check(ctrl_word[12:3] == 10'd16, "R5", "count after early stop", ctrl_word[12:3], 16);
        check(ctrl_word[1:0] == 2'd1, "R5", "mode after early stop", ctrl_word[1:0], 1);

        // R9: stop-mode descriptor ignores every request
        c = mk_ctrl(0, 0, 8, 1, 2, 2, 2);
        load(32'h0000_3000, 32'h0000_4000, c);
        busy_seen = 0;
        req_single = 1'b1; req_burst = 1'b1; req_sw = 1'b1;
        repeat (2) @(negedge clk);
        req_single = 1'b0; req_burst = 1'b0; req_sw = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy_seen, "R9", "busy in stop mode", 32'(busy_seen), 0);
        check(ctrl_word == c, "R9", "ctrl in stop mode", ctrl_word, c);

        // R7/R10: 1024-item auto run from a one-cycle burst pulse, reload attempted mid run
        s = 32'h7000_0000; d = 32'h2000_0FFC; c = mk_ctrl(2, 0, 1024, 0, 2, 3, 2);
        load(s, d, c);
        expect_items(s, d, c, 0, 1024, "R7");
        d0 = done_seen;
        pulse_req(1);
        repeat (20) @(negedge clk);
        load(32'h0BAD_0000, 32'h0BAD_1000, mk_ctrl(1, 1, 7, 5, 0, 0, 0));
        wait_idle();
        check(done_seen == d0 + 1, "R7", "done after full auto run", done_seen, d0 + 1);
        check(ctrl_word[22:13] == c[22:13], "R10", "fields kept over reload",
              ctrl_word[22:13], c[22:13]);
        check(ctrl_word[2:0] == 3'd0, "R10", "mode/flag after run", ctrl_word[2:0], 0);

        check(exp_q.size() == 0, "R3", "pending expected ops", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule